// File: doc/BRIEF.md
# Flash Read Mode Controller

This block decides how a host read of a flash array is served. It has two read modes. In the asynchronous page mode, one page of four words is opened and the host picks a word with the low address bits. In the synchronous burst mode, an internal address counter walks through the array one word per clock after an initial latency, and a wait output tells the host which cycles carry no valid data. The controller drives the array address and an array enable, and it reports standby.

The mode and the initial latency are held in a small read-configuration register that the host writes. After reset the register selects page mode, so burst reads happen only after the host writes that register. A band of small parameter blocks sits at the bottom of the address space or at the top, chosen by a parameter. Any read that starts in that band is served as a single word, whatever the mode. A burst that runs up to the band stops and holds with wait raised.

Once a read ends the block drops into a low-power idle state with the array disabled. Deselecting the chip sends it into standby.

Top module: `flash_read_mode_ctrl`

## Requirements
- R1: After reset the block is in standby (`standby`=1, `arr_en`=0, `rd_wait`=0) and the read mode is page mode. This holds even when burst mode was set before the reset.
- R2: A write with `cfg_we`=1 loads `cfg_data`, where bit 3 is the mode (1 = burst, 0 = page) and bits 2:0 are the initial latency L. The new value applies to reads that start at a later clock edge. A read that starts at the same edge as the write uses the old value.
- R3: A read that starts in a main block in page mode keeps the upper address bits captured at the start. It drives `arr_addr` = {captured bits [AW-1:2], live `rd_addr[1:0]`} with `rd_wait`=0 and `arr_en`=1 for as long as `rd_req` stays high.
- R4: A read that starts in the parameter band is a single-word access in both modes. `arr_addr` stays at the start address whatever `rd_addr` does afterwards, and `rd_wait`=0.
- R5: A burst read that starts in a main block with latency L>0 shows `rd_wait`=1 and `arr_addr` = the start address for exactly L cycles after the start edge. With L=0 the burst data begins at once.
- R6: After the latency, `rd_wait`=0 and `arr_addr` goes up by one word (modulo 2^AW) on every clock, starting from the start address.
- R7: If the next burst address would fall in the parameter band, the burst holds. `arr_addr` stays at the last main-block word and `rd_wait`=1 until the read ends.
- R8: A clock edge with `sel`=1 and `rd_req`=0 leaves the block in low-power idle: `arr_en`=0, `rd_wait`=0, `standby`=0. A read starts at an edge where the block is idle and `rd_req`=1.
- R9: A clock edge with `sel`=0 puts the block in standby (`standby`=1, `arr_en`=0) from any state. This takes priority over every other transition. From standby with `sel`=1, one edge leads to idle.
- R10: The parameter band spans PBLK_COUNT x PBLK_WORDS words. It covers the lowest addresses when PBLK_AT_TOP=0 and the highest addresses when PBLK_AT_TOP=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Chip select, active high; low forces standby |
| rd_req | input | 1 | Read request level; rising level in idle starts a read, low ends it |
| rd_addr | input | ADDR_W | Host word address; low two bits pick the page word in page mode |
| cfg_we | input | 1 | Read-configuration write strobe |
| cfg_data | input | 4 | Bit 3 mode (1 = burst), bits 2:0 initial latency |
| arr_addr | output | ADDR_W | Word address presented to the array |
| arr_en | output | 1 | Array access active |
| rd_wait | output | 1 | High while burst data is not valid |
| standby | output | 1 | High in the deselected standby state |

## Verification
Two events can fall on the same clock edge: a configuration write and the start of a read. The bench makes this happen by raising `cfg_we` and `rd_req` in the same cycle, both toward burst and back toward page. It then checks that the read which starts on that edge behaves in the old mode (wait level and address pattern) and that the next read uses the new one. A burst that hits the parameter band is run against both band placements at once, using two instances with shared inputs. Every start address and every latency value is swept.

// File: rtl/frm_pkg.sv
package frm_pkg;

  localparam int LAT_W = 3;

  typedef enum logic [2:0] {
    ST_STBY   = 3'd0,
    ST_IDLE   = 3'd1,
    ST_PAGE   = 3'd2,
    ST_SINGLE = 3'd3,
    ST_LAT    = 3'd4,
    ST_BURST  = 3'd5,
    ST_HOLD   = 3'd6
  } rd_state_e;

  typedef struct packed {
    logic             burst;
    logic [LAT_W-1:0] lat;
  } rd_cfg_t;

  localparam int CFG_W = $bits(rd_cfg_t);

endpackage

// File: rtl/frm_rst_sync.sv
module frm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) shift_q <= '0;
    else              shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/frm_cfg_reg.sv
module frm_cfg_reg
  import frm_pkg::*;
#(
  parameter int RST_LAT = 7
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  rd_cfg_t wdata,
  output rd_cfg_t cfg_q
);

  rd_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.burst <= 1'b0;
      cfg_q.lat   <= LAT_W'(RST_LAT);
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == $past(wdata)));

endmodule

// File: rtl/frm_region.sv
module frm_region #(
  parameter int ADDR_W      = 20,
  parameter int PBLK_WORDS  = 4096,
  parameter int PBLK_COUNT  = 8,
  parameter bit PBLK_AT_TOP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_param
);

  localparam longint unsigned SPAN    = longint'(PBLK_WORDS) * longint'(PBLK_COUNT);
  localparam longint unsigned FULL    = longint'(1) << ADDR_W;
  localparam logic [ADDR_W:0] LO_LIM  = (ADDR_W+1)'(SPAN);
  localparam logic [ADDR_W:0] HI_BASE = (ADDR_W+1)'(FULL - SPAN);

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr};

  generate
    if (PBLK_AT_TOP) begin : g_top
      assign is_param = (addr_x >= HI_BASE);
    end else begin : g_bottom
      assign is_param = (addr_x < LO_LIM);
    end
  endgenerate

endmodule

// File: rtl/frm_burst_ctr.sv
module frm_burst_ctr #(
  parameter int ADDR_W = 20,
  parameter int LW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LW-1:0]     load_lat,
  input  logic              adv,
  input  logic              lat_dec,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [LW-1:0]     lat_q,
  output logic              lat_last
);

  logic [ADDR_W-1:0] addr_d;
  logic [LW-1:0]     lat_d;

  assign addr_nxt = addr_q + 1'b1;
  assign lat_last = (lat_q == LW'(1));

  always_comb begin
    addr_d = addr_q;
    lat_d  = lat_q;
    if (load) begin
      addr_d = load_addr;
      lat_d  = load_lat;
    end else begin
      if (adv)     addr_d = addr_nxt;
      if (lat_dec) lat_d  = lat_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lat_q  <= '0;
    end else begin
      addr_q <= addr_d;
      lat_q  <= lat_d;
    end
  end

  // R5
  lat_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_dec |-> (lat_q != '0));

endmodule

// File: rtl/flash_read_mode_ctrl.sv
module flash_read_mode_ctrl
  import frm_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int PG_BITS     = 2,
  parameter int PBLK_WORDS  = 4096,
  parameter int PBLK_COUNT  = 8,
  parameter bit PBLK_AT_TOP = 1'b0,
  parameter int RST_LAT     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_data,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_en,
  output logic              rd_wait,
  output logic              standby
);

  logic              rst_n_i;
  rd_cfg_t           cfg_q;
  rd_state_e         st_q, st_d;
  logic              ld, adv, lat_dec;
  logic [ADDR_W-1:0] cnt_addr, cnt_nxt;
  logic [LAT_W-1:0]  lat_q;
  logic              lat_last;
  logic              start_param, nxt_param, cur_param;

  frm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_i)
  );

  frm_cfg_reg #(.RST_LAT(RST_LAT)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n_i),
    .we   (cfg_we),
    .wdata(rd_cfg_t'(cfg_data)),
    .cfg_q(cfg_q)
  );

  frm_burst_ctr #(.ADDR_W(ADDR_W), .LW(LAT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (ld),
    .load_addr(rd_addr),
    .load_lat (cfg_q.lat),
    .adv      (adv),
    .lat_dec  (lat_dec),
    .addr_q   (cnt_addr),
    .addr_nxt (cnt_nxt),
    .lat_q    (lat_q),
    .lat_last (lat_last)
  );

  frm_region #(.ADDR_W(ADDR_W), .PBLK_WORDS(PBLK_WORDS), .PBLK_COUNT(PBLK_COUNT),
               .PBLK_AT_TOP(PBLK_AT_TOP)) u_reg_start (
    .addr    (rd_addr),
    .is_param(start_param)
  );

  frm_region #(.ADDR_W(ADDR_W), .PBLK_WORDS(PBLK_WORDS), .PBLK_COUNT(PBLK_COUNT),
               .PBLK_AT_TOP(PBLK_AT_TOP)) u_reg_next (
    .addr    (cnt_nxt),
    .is_param(nxt_param)
  );

  frm_region #(.ADDR_W(ADDR_W), .PBLK_WORDS(PBLK_WORDS), .PBLK_COUNT(PBLK_COUNT),
               .PBLK_AT_TOP(PBLK_AT_TOP)) u_reg_cur (
    .addr    (cnt_addr),
    .is_param(cur_param)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    adv     = 1'b0;
    lat_dec = 1'b0;
    if (!sel) begin
      st_d = ST_STBY;
    end else begin
      case (st_q)
        ST_STBY: st_d = ST_IDLE;
        ST_IDLE: begin
          if (rd_req) begin
            ld = 1'b1;
            if (start_param)            st_d = ST_SINGLE;
            else if (!cfg_q.burst)      st_d = ST_PAGE;
            else if (cfg_q.lat == '0)   st_d = ST_BURST;
            else                        st_d = ST_LAT;
          end
        end
        ST_PAGE, ST_SINGLE, ST_HOLD: begin
          if (!rd_req) st_d = ST_IDLE;
        end
        ST_LAT: begin
          if (!rd_req) begin
            st_d = ST_IDLE;
          end else begin
            lat_dec = 1'b1;
            if (lat_last) st_d = ST_BURST;
          end
        end
        ST_BURST: begin
          if (!rd_req)        st_d = ST_IDLE;
          else if (nxt_param) st_d = ST_HOLD;
          else                adv  = 1'b1;
        end
        default: st_d = ST_STBY;
      endcase
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) st_q <= ST_STBY;
    else          st_q <= st_d;
  end

  // output decode
  always_comb begin
    arr_en  = 1'b0;
    rd_wait = 1'b0;
    case (st_q)
      ST_PAGE, ST_SINGLE, ST_BURST: arr_en = 1'b1;
      ST_LAT, ST_HOLD: begin
        arr_en  = 1'b1;
        rd_wait = 1'b1;
      end
      default: ;
    endcase
  end

  assign standby  = (st_q == ST_STBY);
  assign arr_addr = (st_q == ST_PAGE) ? {cnt_addr[ADDR_W-1:PG_BITS], rd_addr[PG_BITS-1:0]}
                                      : cnt_addr;

  // R9
  desel_standby_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !sel |=> (standby && !arr_en));

  // R8
  idle_lowpower_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sel && !rd_req) |=> (!arr_en && !rd_wait && !standby));

  // R4
  no_param_burst_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (st_q == ST_BURST) |-> !cur_param);

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((st_q == ST_BURST) && ($past(st_q) == ST_BURST)) |-> (cnt_addr == ADDR_W'($past(cnt_addr) + 1'b1)));

  // R3
  page_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((st_q == ST_IDLE) && sel && rd_req && !cfg_q.burst) |=> !rd_wait);

endmodule

// File: tb/flash_read_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_read_mode_ctrl_tb_top;

  localparam int AW   = 8;
  localparam int BW   = 4;
  localparam int NB   = 2;
  localparam int SPAN = BW * NB;
  localparam int FULL = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_data = '0;

  logic [1:0][AW-1:0] o_addr;
  logic [1:0] o_en, o_wait, o_sb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_read_mode_ctrl #(.ADDR_W(AW), .PBLK_WORDS(BW), .PBLK_COUNT(NB), .PBLK_AT_TOP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_req(rd_req), .rd_addr(rd_addr),
    .cfg_we(cfg_we), .cfg_data(cfg_data),
    .arr_addr(o_addr[0]), .arr_en(o_en[0]), .rd_wait(o_wait[0]), .standby(o_sb[0])
  );

  flash_read_mode_ctrl #(.ADDR_W(AW), .PBLK_WORDS(BW), .PBLK_COUNT(NB), .PBLK_AT_TOP(1'b1)) dut_t_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_req(rd_req), .rd_addr(rd_addr),
    .cfg_we(cfg_we), .cfg_data(cfg_data),
    .arr_addr(o_addr[1]), .arr_en(o_en[1]), .rd_wait(o_wait[1]), .standby(o_sb[1])
  );

  function automatic bit is_par(int a, int top);
    if (top != 0) return (a >= FULL - SPAN);
    return (a < SPAN);
  endfunction

  task automatic chk(string req, string what, int inst, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s inst=%0d actual=%0d expected=%0d", req, what, inst, act, exp);
    end
  endtask

  task automatic chk_quiet(string req, int sb_exp);
    for (int i = 0; i < 2; i++) begin
      chk(req, "arr_en", i, int'(o_en[i]), 0);
      chk(req, "rd_wait", i, int'(o_wait[i]), 0);
      chk(req, "standby", i, int'(o_sb[i]), sb_exp);
    end
  endtask

  task automatic wcfg(bit burst, int lat);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_data = {burst, 3'(lat)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one read from address a for n observed cycles; mode/lat are the values the read must use.
  task automatic run_access(int a, bit burst, int lat, int n, bit do_w, logic [3:0] wd, string tag);
    int cur [2];
    bit hold [2];
    @(negedge clk);
    rd_addr = AW'(a);
    rd_req = 1'b1;
    cfg_we = do_w;
    cfg_data = wd;
    for (int i = 0; i < 2; i++) begin cur[i] = a; hold[i] = 1'b0; end
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      rd_addr = {AW'(a) >> 2, 2'(j + 1)};
      #1;
      for (int i = 0; i < 2; i++) begin
        int ea;
        int ew;
        string rq;
        if (is_par(a, i)) begin
          ea = a; ew = 0; rq = "R4 R10";
        end else if (!burst) begin
          ea = ((a >> 2) << 2) | ((j + 1) & 3); ew = 0; rq = "R3";
        end else if (j < lat) begin
          ea = a; ew = 1; rq = "R5";
        end else begin
          ea = cur[i]; ew = hold[i] ? 1 : 0; rq = hold[i] ? "R7" : "R6";
          if (!hold[i]) begin
            if (is_par((cur[i] + 1) % FULL, i)) hold[i] = 1'b1;
            else cur[i] = (cur[i] + 1) % FULL;
          end
        end
        if (tag.len() != 0) rq = tag;
        chk(rq, "arr_addr", i, int'(o_addr[i]), ea);
        chk(rq, "rd_wait", i, int'(o_wait[i]), ew);
        chk(rq, "arr_en", i, int'(o_en[i]), 1);
      end
    end
    rd_req = 1'b0;
    @(negedge clk);
    chk_quiet("R8", 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_quiet("R1", 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_quiet("R1", 1);
    sel = 1'b1;
    @(negedge clk);
    chk_quiet("R9", 0);

    // R3 R4: default page mode sweep over every start address
    for (int a = 0; a < FULL; a++) run_access(a, 1'b0, 0, 5, 1'b0, 4'd0, "");

    // R5 R6 R7: burst sweep, every start and every latency
    for (int a = 0; a < FULL; a++) begin
      wcfg(1'b1, a % 8);
      run_access(a, 1'b1, a % 8, 14, 1'b0, 4'd0, "");
    end

    // R2: write toward page at the same edge as a read start -> old burst setting used
    wcfg(1'b1, 2);
    run_access(100, 1'b1, 2, 6, 1'b1, 4'b0000, "R2");
    run_access(101, 1'b0, 0, 4, 1'b0, 4'd0, "R2");
    // R2: write toward burst at the same edge as a read start -> old page setting used
    run_access(120, 1'b0, 0, 4, 1'b1, 4'b1011, "R2");
    run_access(121, 1'b1, 3, 7, 1'b0, 4'd0, "R2");

    // R9: deselect in the middle of a burst
    @(negedge clk);
    rd_addr = 8'd60;
    rd_req = 1'b1;
    repeat (5) @(negedge clk);
    sel = 1'b0;
    @(negedge clk);
    chk_quiet("R9", 1);
    rd_req = 1'b0;
    sel = 1'b1;
    @(negedge clk);
    chk_quiet("R9", 0);

    // R1: reset during a burst returns to page mode
    @(negedge clk);
    rd_addr = 8'd70;
    rd_req = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_quiet("R1", 1);
    rd_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_quiet("R1", 0);
    run_access(77, 1'b0, 0, 5, 1'b0, 4'd0, "R1");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule